// File: doc/BRIEF.md
# Address Register Load/Store Unit

This unit sits beside the execute stage of a small dual-stack processor. It holds the two address registers (a general register called A and a write-only register called B) and carries out every opcode that moves a cell between the top of the data stack and memory. An access never takes its address from a stack value. The address comes from the program counter value supplied by the fetch sequencer, from A, or from B.

An address has two halves. When the top address bit is clear, the access goes to the 64-cell local RAM held inside the unit. When that bit is set, the access goes out on the port interface instead. The plus variants step A after the access, and P-based accesses ask the fetch sequencer to step P. Neither step happens when the register holds a port address.

A store takes the value of T from the request and signals a pop. A fetch, and the opcode that copies A to T, hand a value back for a push two clock edges after the request. A request is accepted on any cycle in which the request valid input is high, with no stall.

Top module: `addr_lsu`

## Requirements
- R1: Synchronous active-high reset sets A to 0 and B to the console port address (parameter, default 9'h115), and holds t_pop, p_inc, push_valid, port_re and port_we low. A reset that arrives in mid-operation gives the same state.
- R2: Only the opcodes 08–0f, 1b, 1e and 1f are acted on, and only when req_valid is 1. Any other opcode, and any request with req_valid at 0, produces no pop, no push, no port strobe and no change to A or B.
- R3: Opcode 1f loads A from T and pops. Opcode 1b pushes the value of A, zero-extended.
- R4: Opcode 1e loads B from T and pops. No opcode returns the value of B.
- R5: Opcodes 0b (fetch) and 0f (store) address through A and leave A unchanged. Opcodes 09 (fetch) and 0d (store) address through A and then add one to A bits 7:0, wrapping from ff to 00 while bit 8 stays unchanged.
- R6: Opcodes 0a (fetch) and 0e (store) address through B, and B never changes when they run.
- R7: Opcodes 08 (fetch) and 0c (store) address through p_in. p_inc pulses for one cycle, one edge after the request, when p_in bit 8 is 0, and stays low when bit 8 is 1.
- R8: Address bit 8 at 1 selects port space. The access raises port_re or port_we together with port_addr and port_wdata, and it does not touch the RAM. A holding a port address is not stepped by 09 or 0d. RAM cells are selected by address bits 5:0 only, so bits 7:6 alias.
- R9: t_pop, p_inc and the port strobes are valid in the cycle after the request edge. push_valid and push_data are valid one edge later. Port read data is sampled on the edge after port_re.
- R10: A fetch issued on the cycle directly after a store to the same RAM cell returns the stored value.
- R11: A store pops T and never pushes. A fetch pushes and never pops.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request from the execute stage is present |
| req_op | input | 5 | Opcode of the request |
| t_in | input | DW | Current top of data stack |
| p_in | input | AW | Current program counter value |
| t_pop | output | 1 | Pop T (store, A load, B load) |
| p_inc | output | 1 | Ask the fetch sequencer to step P |
| push_valid | output | 1 | push_data is to be pushed onto the data stack |
| push_data | output | DW | Value to push |
| port_re | output | 1 | Port-space read strobe |
| port_we | output | 1 | Port-space write strobe |
| port_addr | output | AW | Port-space address |
| port_wdata | output | DW | Port-space write data |
| port_rdata | input | DW | Port-space read data, sampled the edge after port_re |

## Verification
The hardest states to reach are at the edge of the address space. One is A sitting at the last RAM-half address, where a post-increment has to wrap inside the low byte and must not carry into the port-select bit. The other is A holding a port address, where the plus variants must leave it alone. Neither state can be seen directly, because A is internal and B cannot be read back at all. To reach them, the stimulus loads A with 0ff through 1f, runs a store-increment, and then reads A through opcode 1b. It also loads a port address into A and reads it back after a fetch-increment. B is checked indirectly: two fetches in a row through B must return the same cell, and a reset is applied part-way through the run.

// File: rtl/addr_lsu_pkg.sv
package addr_lsu_pkg;

  typedef enum logic [4:0] {
    OP_FETCH_P  = 5'h08,
    OP_FETCH_AI = 5'h09,
    OP_FETCH_B  = 5'h0a,
    OP_FETCH_A  = 5'h0b,
    OP_STORE_P  = 5'h0c,
    OP_STORE_AI = 5'h0d,
    OP_STORE_B  = 5'h0e,
    OP_STORE_A  = 5'h0f,
    OP_READ_A   = 5'h1b,
    OP_LOAD_B   = 5'h1e,
    OP_LOAD_A   = 5'h1f
  } lsu_op_e;

  typedef enum logic [1:0] {
    SRC_P = 2'd0,
    SRC_A = 2'd1,
    SRC_B = 2'd2
  } addr_src_e;

  typedef enum logic [1:0] {
    PUSH_RAM  = 2'd0,
    PUSH_PORT = 2'd1,
    PUSH_AREG = 2'd2
  } push_src_e;

  typedef struct packed {
    logic      rd;
    logic      wr;
    addr_src_e src;
    logic      a_inc;
    logic      p_step;
    logic      ld_a;
    logic      ld_b;
    logic      rd_a;
  } lsu_ctl_t;

endpackage

// File: rtl/addr_lsu_decode.sv
module addr_lsu_decode
  import addr_lsu_pkg::*;
(
  input  logic       req_valid,
  input  logic [4:0] req_op,
  output lsu_ctl_t   ctl
);

  always_comb begin
    ctl = '0;
    ctl.src = SRC_A;
    if (req_valid) begin
      case (req_op)
        OP_FETCH_P:  begin ctl.rd = 1'b1; ctl.src = SRC_P; ctl.p_step = 1'b1; end
        OP_FETCH_AI: begin ctl.rd = 1'b1; ctl.src = SRC_A; ctl.a_inc  = 1'b1; end
        OP_FETCH_B:  begin ctl.rd = 1'b1; ctl.src = SRC_B; end
        OP_FETCH_A:  begin ctl.rd = 1'b1; ctl.src = SRC_A; end
        OP_STORE_P:  begin ctl.wr = 1'b1; ctl.src = SRC_P; ctl.p_step = 1'b1; end
        OP_STORE_AI: begin ctl.wr = 1'b1; ctl.src = SRC_A; ctl.a_inc  = 1'b1; end
        OP_STORE_B:  begin ctl.wr = 1'b1; ctl.src = SRC_B; end
        OP_STORE_A:  begin ctl.wr = 1'b1; ctl.src = SRC_A; end
        OP_READ_A:   ctl.rd_a = 1'b1;
        OP_LOAD_B:   ctl.ld_b = 1'b1;
        OP_LOAD_A:   ctl.ld_a = 1'b1;
        default:     ctl = '0;
      endcase
    end
  end

endmodule

// File: rtl/addr_lsu_regs.sv
module addr_lsu_regs #(
  parameter int          AW           = 9,
  parameter int unsigned CONSOLE_ADDR = 'h115
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ld_a,
  input  logic          ld_b,
  input  logic          a_inc,
  input  logic [AW-1:0] t_addr,
  output logic [AW-1:0] a_q,
  output logic [AW-1:0] b_q
);

  localparam int PORT_BIT = AW - 1;

  logic a_in_port;
  assign a_in_port = a_q[PORT_BIT];

  always_ff @(posedge clk) begin
    if (rst) begin
      a_q <= '0;
      b_q <= AW'(CONSOLE_ADDR);
    end else begin
      if (ld_a) begin
        a_q <= t_addr;
      end else if (a_inc && !a_in_port) begin
        a_q[PORT_BIT-1:0] <= a_q[PORT_BIT-1:0] + 1'b1;
      end
      if (ld_b) begin
        b_q <= t_addr;
      end
    end
  end

  AST_B_HOLD: assert property (@(posedge clk) disable iff (rst)
    !ld_b |=> $stable(b_q));  // R6

  AST_A_PORT_HOLD: assert property (@(posedge clk) disable iff (rst)
    (a_in_port && !ld_a) |=> $stable(a_q));  // R8

endmodule

// File: rtl/addr_lsu_ram.sv
module addr_lsu_ram #(
  parameter int DW    = 18,
  parameter int DEPTH = 64,
  parameter int RAW   = 6
) (
  input  logic           clk,
  input  logic           we,
  input  logic           re,
  input  logic [RAW-1:0] addr,
  input  logic [DW-1:0]  wdata,
  output logic [DW-1:0]  rdata
);

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) begin
      mem[addr] <= wdata;
    end
    if (re) begin
      rdata <= mem[addr];
    end
  end

endmodule

// File: rtl/addr_lsu.sv
module addr_lsu
  import addr_lsu_pkg::*;
#(
  parameter int          DW           = 18,
  parameter int          AW           = 9,
  parameter int          RAM_DEPTH    = 64,
  parameter int unsigned CONSOLE_ADDR = 'h115
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          req_valid,
  input  logic [4:0]    req_op,
  input  logic [DW-1:0] t_in,
  input  logic [AW-1:0] p_in,
  output logic          t_pop,
  output logic          p_inc,
  output logic          push_valid,
  output logic [DW-1:0] push_data,
  output logic          port_re,
  output logic          port_we,
  output logic [AW-1:0] port_addr,
  output logic [DW-1:0] port_wdata,
  input  logic [DW-1:0] port_rdata
);

  localparam int RAM_AW   = $clog2(RAM_DEPTH);
  localparam int PORT_BIT = AW - 1;

  lsu_ctl_t        ctl;
  logic [AW-1:0]   a_q;
  logic [AW-1:0]   b_q;
  logic [AW-1:0]   acc_addr;
  logic            acc_port;

  // stage 1: access request
  logic              s1_ram_rd;
  logic              s1_ram_wr;
  logic [RAM_AW-1:0] s1_ram_addr;
  logic [DW-1:0]     s1_wdata;
  logic              s1_rd_a;
  logic [AW-1:0]     s1_aval;

  // stage 2: push result
  logic [DW-1:0]     ram_q;
  logic [DW-1:0]     port_q;
  logic [AW-1:0]     areg_q;
  push_src_e         push_src;

  addr_lsu_decode u_decode (
    .req_valid (req_valid),
    .req_op    (req_op),
    .ctl       (ctl)
  );

  addr_lsu_regs #(
    .AW           (AW),
    .CONSOLE_ADDR (CONSOLE_ADDR)
  ) u_regs (
    .clk    (clk),
    .rst    (rst),
    .ld_a   (ctl.ld_a),
    .ld_b   (ctl.ld_b),
    .a_inc  (ctl.a_inc),
    .t_addr (t_in[AW-1:0]),
    .a_q    (a_q),
    .b_q    (b_q)
  );

  always_comb begin
    case (ctl.src)
      SRC_P:   acc_addr = p_in;
      SRC_B:   acc_addr = b_q;
      default: acc_addr = a_q;
    endcase
  end

  assign acc_port = acc_addr[PORT_BIT];

  always_ff @(posedge clk) begin
    if (rst) begin
      t_pop       <= 1'b0;
      p_inc       <= 1'b0;
      port_re     <= 1'b0;
      port_we     <= 1'b0;
      port_addr   <= '0;
      port_wdata  <= '0;
      s1_ram_rd   <= 1'b0;
      s1_ram_wr   <= 1'b0;
      s1_ram_addr <= '0;
      s1_wdata    <= '0;
      s1_rd_a     <= 1'b0;
      s1_aval     <= '0;
    end else begin
      t_pop       <= ctl.wr | ctl.ld_a | ctl.ld_b;
      p_inc       <= ctl.p_step & ~p_in[PORT_BIT];
      port_re     <= ctl.rd & acc_port;
      port_we     <= ctl.wr & acc_port;
      port_addr   <= acc_addr;
      port_wdata  <= t_in;
      s1_ram_rd   <= ctl.rd & ~acc_port;
      s1_ram_wr   <= ctl.wr & ~acc_port;
      s1_ram_addr <= acc_addr[RAM_AW-1:0];
      s1_wdata    <= t_in;
      s1_rd_a     <= ctl.rd_a;
      s1_aval     <= a_q;
    end
  end

  addr_lsu_ram #(
    .DW    (DW),
    .DEPTH (RAM_DEPTH),
    .RAW   (RAM_AW)
  ) u_ram (
    .clk   (clk),
    .we    (s1_ram_wr),
    .re    (s1_ram_rd),
    .addr  (s1_ram_addr),
    .wdata (s1_wdata),
    .rdata (ram_q)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      push_valid <= 1'b0;
      push_src   <= PUSH_RAM;
      port_q     <= '0;
      areg_q     <= '0;
    end else begin
      push_valid <= port_re | s1_ram_rd | s1_rd_a;
      if (s1_rd_a)      push_src <= PUSH_AREG;
      else if (port_re) push_src <= PUSH_PORT;
      else              push_src <= PUSH_RAM;
      if (port_re) port_q <= port_rdata;
      areg_q <= s1_aval;
    end
  end

  always_comb begin
    case (push_src)
      PUSH_PORT: push_data = port_q;
      PUSH_AREG: push_data = DW'(areg_q);
      default:   push_data = ram_q;
    endcase
  end

  AST_PORT_ONE_DIR: assert property (@(posedge clk) disable iff (rst)
    !(port_re && port_we));  // R8

  AST_PINC_RAM_ONLY: assert property (@(posedge clk) disable iff (rst)
    p_inc |-> !$past(p_in[PORT_BIT]));  // R7

  AST_STORE_NO_PUSH: assert property (@(posedge clk) disable iff (rst)
    port_we |=> !push_valid);  // R11

endmodule

// File: tb/addr_lsu_bench.sv
module addr_lsu_bench;

  localparam int DW = 18;
  localparam int AW = 9;

  logic          clk = 1'b0;
  logic          rst;
  logic          req_valid;
  logic [4:0]    req_op;
  logic [DW-1:0] t_in;
  logic [AW-1:0] p_in;
  logic          t_pop;
  logic          p_inc;
  logic          push_valid;
  logic [DW-1:0] push_data;
  logic          port_re;
  logic          port_we;
  logic [AW-1:0] port_addr;
  logic [DW-1:0] port_wdata;
  logic [DW-1:0] port_rdata;

  int total = 0;
  int bad   = 0;

  always #5 clk = ~clk;

  // port model: read data is a fixed tag ored with the address
  assign port_rdata = 18'h2A000 | DW'(port_addr);

  addr_lsu u_addr_lsu (
    .clk        (clk),
    .rst        (rst),
    .req_valid  (req_valid),
    .req_op     (req_op),
    .t_in       (t_in),
    .p_in       (p_in),
    .t_pop      (t_pop),
    .p_inc      (p_inc),
    .push_valid (push_valid),
    .push_data  (push_data),
    .port_re    (port_re),
    .port_we    (port_we),
    .port_addr  (port_addr),
    .port_wdata (port_wdata),
    .port_rdata (port_rdata)
  );

  typedef struct packed {
    logic [3:0]    rq;
    logic [4:0]    op;
    logic [DW-1:0] t;
    logic [AW-1:0] p;
    logic          pop;
    logic          pinc;
    logic          pre;
    logic          pwe;
    logic [AW-1:0] paddr;
    logic [DW-1:0] pwd;
    logic          pv;
    logic [DW-1:0] pd;
  } vec_t;

  localparam int NV = 28;
  localparam vec_t VEC [NV] = '{
    '{4'd3,  5'h1f, 18'h00005, 9'h000, 1'b1, 1'b0, 1'b0, 1'b0, 9'h000, 18'h0, 1'b0, 18'h0},     // R3 A=5
    '{4'd5,  5'h0d, 18'h00111, 9'h000, 1'b1, 1'b0, 1'b0, 1'b0, 9'h000, 18'h0, 1'b0, 18'h0},     // R5 ram5, A=6
    '{4'd5,  5'h0f, 18'h00222, 9'h000, 1'b1, 1'b0, 1'b0, 1'b0, 9'h000, 18'h0, 1'b0, 18'h0},     // R5 ram6
    '{4'd3,  5'h1b, 18'h0,     9'h000, 1'b0, 1'b0, 1'b0, 1'b0, 9'h000, 18'h0, 1'b1, 18'h00006}, // R3 A=6
    '{4'd5,  5'h0b, 18'h0,     9'h000, 1'b0, 1'b0, 1'b0, 1'b0, 9'h000, 18'h0, 1'b1, 18'h00222}, // R5
    '{4'd3,  5'h1f, 18'h00005, 9'h000, 1'b1, 1'b0, 1'b0, 1'b0, 9'h000, 18'h0, 1'b0, 18'h0},     // R3
    '{4'd5,  5'h09, 18'h0,     9'h000, 1'b0, 1'b0, 1'b0, 1'b0, 9'h000, 18'h0, 1'b1, 18'h00111}, // R5
    '{4'd5,  5'h1b, 18'h0,     9'h000, 1'b0, 1'b0, 1'b0, 1'b0, 9'h000, 18'h0, 1'b1, 18'h00006}, // R5 stepped
    '{4'd8,  5'h0a, 18'h0,     9'h000, 1'b0, 1'b0, 1'b1, 1'b0, 9'h115, 18'h0, 1'b1, 18'h2A115}, // R8 port read via B
    '{4'd8,  5'h0e, 18'h000AB, 9'h000, 1'b1, 1'b0, 1'b0, 1'b1, 9'h115, 18'h000AB, 1'b0, 18'h0}, // R8 port write
    '{4'd4,  5'h1e, 18'h00003, 9'h000, 1'b1, 1'b0, 1'b0, 1'b0, 9'h000, 18'h0, 1'b0, 18'h0},     // R4 B=3
    '{4'd6,  5'h0e, 18'h00333, 9'h000, 1'b1, 1'b0, 1'b0, 1'b0, 9'h000, 18'h0, 1'b0, 18'h0},     // R6 ram3
    '{4'd6,  5'h0a, 18'h0,     9'h000, 1'b0, 1'b0, 1'b0, 1'b0, 9'h000, 18'h0, 1'b1, 18'h00333}, // R6
    '{4'd6,  5'h0a, 18'h0,     9'h000, 1'b0, 1'b0, 1'b0, 1'b0, 9'h000, 18'h0, 1'b1, 18'h00333}, // R6 B still 3
    '{4'd7,  5'h0c, 18'h00444, 9'h010, 1'b1, 1'b1, 1'b0, 1'b0, 9'h000, 18'h0, 1'b0, 18'h0},     // R7 store via P
    '{4'd7,  5'h08, 18'h0,     9'h010, 1'b0, 1'b1, 1'b0, 1'b0, 9'h000, 18'h0, 1'b1, 18'h00444}, // R7 fetch via P
    '{4'd7,  5'h08, 18'h0,     9'h120, 1'b0, 1'b0, 1'b1, 1'b0, 9'h120, 18'h0, 1'b1, 18'h2A120}, // R7 P in port space
    '{4'd7,  5'h0c, 18'h000CD, 9'h121, 1'b1, 1'b0, 1'b0, 1'b1, 9'h121, 18'h000CD, 1'b0, 18'h0}, // R7 no step
    '{4'd8,  5'h1f, 18'h00130, 9'h000, 1'b1, 1'b0, 1'b0, 1'b0, 9'h000, 18'h0, 1'b0, 18'h0},     // R8 A=port
    '{4'd8,  5'h09, 18'h0,     9'h000, 1'b0, 1'b0, 1'b1, 1'b0, 9'h130, 18'h0, 1'b1, 18'h2A130}, // R8
    '{4'd8,  5'h1b, 18'h0,     9'h000, 1'b0, 1'b0, 1'b0, 1'b0, 9'h000, 18'h0, 1'b1, 18'h00130}, // R8 A held
    '{4'd5,  5'h1f, 18'h000FF, 9'h000, 1'b1, 1'b0, 1'b0, 1'b0, 9'h000, 18'h0, 1'b0, 18'h0},     // R5 A=ff
    '{4'd5,  5'h0d, 18'h00555, 9'h000, 1'b1, 1'b0, 1'b0, 1'b0, 9'h000, 18'h0, 1'b0, 18'h0},     // R5 ram3f
    '{4'd5,  5'h1b, 18'h0,     9'h000, 1'b0, 1'b0, 1'b0, 1'b0, 9'h000, 18'h0, 1'b1, 18'h00000}, // R5 wrap
    '{4'd8,  5'h1f, 18'h0003F, 9'h000, 1'b1, 1'b0, 1'b0, 1'b0, 9'h000, 18'h0, 1'b0, 18'h0},     // R8
    '{4'd8,  5'h0b, 18'h0,     9'h000, 1'b0, 1'b0, 1'b0, 1'b0, 9'h000, 18'h0, 1'b1, 18'h00555}, // R8 alias
    '{4'd2,  5'h14, 18'h001FF, 9'h000, 1'b0, 1'b0, 1'b0, 1'b0, 9'h000, 18'h0, 1'b0, 18'h0},     // R2 other op
    '{4'd2,  5'h1b, 18'h0,     9'h000, 1'b0, 1'b0, 1'b0, 1'b0, 9'h000, 18'h0, 1'b1, 18'h0003F}  // R2 A kept
  };

  task automatic check(input bit ok, input int rq, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL R%0d %s act=%h exp=%h", rq, what, act, exp);
    end
  endtask

  task automatic issue(input logic [4:0] op, input logic [DW-1:0] t, input logic [AW-1:0] p);
    @(negedge clk);
    req_valid = 1'b1;
    req_op    = op;
    t_in      = t;
    p_in      = p;
  endtask

  task automatic idle();
    @(negedge clk);
    req_valid = 1'b0;
    req_op    = 5'h1c;
  endtask

  // one request, stage-1 check one edge later, push check one edge after that
  task automatic run_vec(input vec_t v);
    issue(v.op, v.t, v.p);
    idle();
    check(t_pop == v.pop, v.rq, "t_pop", 32'(t_pop), 32'(v.pop));
    check(p_inc == v.pinc, v.rq, "p_inc", 32'(p_inc), 32'(v.pinc));
    check(port_re == v.pre && port_we == v.pwe, v.rq, "port strobes",
          32'({port_re, port_we}), 32'({v.pre, v.pwe}));
    if (v.pre || v.pwe)
      check(port_addr == v.paddr, v.rq, "port_addr", 32'(port_addr), 32'(v.paddr));
    if (v.pwe)
      check(port_wdata == v.pwd, v.rq, "port_wdata", 32'(port_wdata), 32'(v.pwd));
    @(negedge clk);
    check(push_valid == v.pv, v.rq, "push_valid", 32'(push_valid), 32'(v.pv));
    if (v.pv)
      check(push_data == v.pd, v.rq, "push_data", 32'(push_data), 32'(v.pd));
  endtask

  task automatic expect_push(input int rq, input logic [DW-1:0] op_val, input logic [DW-1:0] exp);
    issue(5'(op_val), '0, '0);
    idle();
    @(negedge clk);
    check(push_valid && push_data == exp, rq, "push", 32'(push_data), 32'(exp));
  endtask

  initial begin
    rst = 1'b1; req_valid = 1'b0; req_op = 5'h1c; t_in = '0; p_in = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    check(!t_pop && !p_inc && !push_valid && !port_re && !port_we, 1, "outputs after reset",
          32'({t_pop, p_inc, push_valid, port_re, port_we}), 32'h0);
    expect_push(1, 18'h1b, 18'h0);  // R1 A=0
    issue(5'h0a, '0, '0);
    idle();
    check(port_re && port_addr == 9'h115, 1, "B reset addr", 32'(port_addr), 32'h115);  // R1
    @(negedge clk);

    for (int i = 0; i < NV; i++) run_vec(VEC[i]);

    // R2 req_valid low: load A must not happen
    @(negedge clk);
    req_valid = 1'b0; req_op = 5'h1f; t_in = 18'h000AA;
    @(negedge clk);
    check(!t_pop, 2, "pop with valid low", 32'(t_pop), 32'h0);
    expect_push(2, 18'h1b, 18'h0003F);

    // R10 store then fetch on the next cycle, same cell
    run_vec('{4'd10, 5'h1f, 18'h00020, 9'h0, 1'b1, 1'b0, 1'b0, 1'b0, 9'h0, 18'h0, 1'b0, 18'h0});
    issue(5'h0f, 18'h00777, '0);
    issue(5'h0b, '0, '0);
    idle();
    check(!push_valid, 11, "push after store", 32'(push_valid), 32'h0);  // R11
    @(negedge clk);
    check(push_valid && push_data == 18'h00777, 10, "back-to-back fetch",
          32'(push_data), 32'h777);  // R10

    // R9 port read data sampled on the edge after port_re
    issue(5'h08, '0, 9'h1A5);
    idle();
    check(port_re && !push_valid, 9, "strobe before push", 32'({port_re, push_valid}), 32'h2);
    @(negedge clk);
    check(push_valid && push_data == 18'h2A1A5, 9, "port push", 32'(push_data), 32'h2A1A5);

    // R1 reset in mid-operation
    run_vec('{4'd1, 5'h1f, 18'h00055, 9'h0, 1'b1, 1'b0, 1'b0, 1'b0, 9'h0, 18'h0, 1'b0, 18'h0});
    run_vec('{4'd1, 5'h1e, 18'h00007, 9'h0, 1'b1, 1'b0, 1'b0, 1'b0, 9'h0, 18'h0, 1'b0, 18'h0});
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    expect_push(1, 18'h1b, 18'h0);
    issue(5'h0a, '0, '0);
    idle();
    check(port_re && port_addr == 9'h115, 1, "B after mid reset", 32'(port_addr), 32'h115);
    @(negedge clk);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL R9 watchdog act=%h exp=%h", 32'h1, 32'h0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule